// File: doc/BRIEF.md
# Serial Divider-Setting Loader

This block receives divider settings for a frequency synthesizer over a three-wire serial link made of a bit clock, a data line and a load strobe. It runs on a fast system clock and resynchronises all three wires. On each rising edge of the serial clock it shifts one data bit into a window that holds the most recent bits.

When the load strobe rises, the block looks at the two youngest bits of that window. These two bits are a routing trailer. They pick one of two holding registers: a 17-bit reference-divider word or an 18-bit feedback-divider word. The payload sits just above the trailer. The chosen register takes the payload, and a matching update flag is high for one system clock.

The link carries no stream, so there is no valid/ready pair and no back-pressure. The words are held levels, and the update flags are plain one-cycle pulses that a consumer may ignore. The serial source must keep each wire level long enough for the synchroniser to see it.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset both held words are zero and both update flags are low.
- R2: Each rising edge of the serial clock shifts one data bit in, first bit sent being the most significant. Data settles before the clock edge that samples it.
- R3: On a rising load strobe, when window bits [1:0] equal 2'b11, the reference word takes window bits [18:2] and the feedback word keeps its value.
- R4: On a rising load strobe, when window bits [1:0] equal 2'b01, the feedback word takes window bits [19:2] and the reference word keeps its value.
- R5: On a rising load strobe, when window bits [1:0] equal 2'b00 or 2'b10, neither word changes and neither update flag rises.
- R6: Each successful transfer raises exactly one update flag, the one for the written word, for exactly one system clock. Holding the strobe high does not repeat the transfer.
- R7: Only the 20 most recent bits count. Bits sent before them, and bit 19 on a reference transfer, have no effect.
- R8: A serial clock rise and a strobe rise seen in the same system cycle transfer the window including the bit shifted in that cycle.
- R9: A held word changes only in the cycle its update flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe; low while shifting, rising edge transfers |
| ref_word | output | 17 | Held reference-divider setting |
| ref_upd | output | 1 | One-cycle pulse when ref_word is written |
| fb_word | output | 18 | Held feedback-divider setting |
| fb_upd | output | 1 | One-cycle pulse when fb_word is written |

## Verification
Shifting and transfer can fall in the same system cycle when the last serial clock edge and the strobe edge arrive together. The bench raises both wires in the same instant after sending all but the final trailer bit. It picks a payload whose last bit would turn the stale window into a feedback code. The only correct result is a reference write containing the full payload with no feedback pulse, so a design that ignored the coincident bit would write the wrong register.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    RT_NONE0 = 2'b00,
    RT_FB    = 2'b01,
    RT_NONE1 = 2'b10,
    RT_REF   = 2'b11
  } route_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_in,
  output logic [LANES-1:0] level,
  output logic [LANES-1:0] rise
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    logic              last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain  <= '0;
        last_q <= 1'b0;
      end else begin
        if (STAGES > 1) chain <= {chain[STAGES-2:0], async_in[g]};
        else            chain <= async_in[g];
        last_q <= chain[STAGES-1];
      end
    end
    assign level[g] = chain[STAGES-1];
    assign rise[g]  = chain[STAGES-1] & ~last_q;
  end
endmodule

// File: rtl/synth_prog_shreg.sv
module synth_prog_shreg #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] window_next
);
  logic [WIDTH-1:0] window_q;

  always_comb begin
    window_next = window_q;
    if (shift_en) window_next = {window_q[WIDTH-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) window_q <= '0;
    else        window_q <= window_next;
  end
endmodule

// File: rtl/synth_prog_xfer.sv
module synth_prog_xfer
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_W = 17,
  parameter int unsigned FB_W  = 18,
  parameter int unsigned WIN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIN_W-1:0] window,
  output logic [REF_W-1:0] ref_word,
  output logic             ref_upd,
  output logic [FB_W-1:0]  fb_word,
  output logic             fb_upd
);
  route_e route;
  assign route = route_e'(window[SEL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_word <= '0;
      fb_word  <= '0;
      ref_upd  <= 1'b0;
      fb_upd   <= 1'b0;
    end else begin
      ref_upd <= 1'b0;
      fb_upd  <= 1'b0;
      if (strobe) begin
        unique case (route)
          RT_REF: begin
            ref_word <= window[SEL_W +: REF_W];
            ref_upd  <= 1'b1;
          end
          RT_FB: begin
            fb_word <= window[SEL_W +: FB_W];
            fb_upd  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_W       = 17,
  parameter int unsigned FB_W        = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  output logic [REF_W-1:0] ref_word,
  output logic             ref_upd,
  output logic [FB_W-1:0]  fb_word,
  output logic             fb_upd
);
  localparam int unsigned WIN_W = max_u(REF_W, FB_W) + SEL_W;
  localparam int unsigned LN_CLK = 0;
  localparam int unsigned LN_DAT = 1;
  localparam int unsigned LN_LE  = 2;

  logic [2:0]       pins, lvl, rise;
  logic [WIN_W-1:0] win_next;

  assign pins[LN_CLK] = ser_clk;
  assign pins[LN_DAT] = ser_dat;
  assign pins[LN_LE]  = ser_le;

  synth_prog_sync #(.LANES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins), .level(lvl), .rise(rise)
  );

  synth_prog_shreg #(.WIDTH(WIN_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .shift_en(rise[LN_CLK]),
    .bit_in(lvl[LN_DAT]), .window_next(win_next)
  );

  synth_prog_xfer #(.REF_W(REF_W), .FB_W(FB_W), .WIN_W(WIN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .strobe(rise[LN_LE]), .window(win_next),
    .ref_word(ref_word), .ref_upd(ref_upd), .fb_word(fb_word), .fb_upd(fb_upd)
  );
endmodule

// File: rtl/synth_prog_loader_chk.sv
module synth_prog_loader_chk #(
  parameter int unsigned REF_W = 17,
  parameter int unsigned FB_W  = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REF_W-1:0] ref_word,
  input logic             ref_upd,
  input logic [FB_W-1:0]  fb_word,
  input logic             fb_upd
);
  // R6: a pulse never lasts two cycles
  a_r6_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd);
  a_r6_fb_single: assert property (@(posedge clk) disable iff (!rst_n)
    fb_upd |=> !fb_upd);
  // R6: one transfer raises only one flag
  a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_upd && fb_upd));
  // R9: held words move only with their flag
  a_r9_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> $stable(ref_word));
  a_r9_fb_held: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_upd |-> $stable(fb_word));
endmodule

bind synth_prog_loader synth_prog_loader_chk #(.REF_W(REF_W), .FB_W(FB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_word(ref_word), .ref_upd(ref_upd),
  .fb_word(fb_word), .fb_upd(fb_upd)
);

// File: tb/synth_prog_loader_tb.sv
module synth_prog_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 12;
  localparam int NV = 7;
  // entry: [24:20] bit count, [19:0] frame (bit 19 sent first when count>=20)
  localparam logic [24:0] VEC [NV] = '{
    {5'd19, 1'b0, 17'h1ABCD, 2'b11},
    {5'd20, 18'h2F0F3, 2'b01},
    {5'd20, 18'h15555, 2'b00},
    {5'd19, 1'b0, 17'h00001, 2'b10},
    {5'd23, 18'h20001, 2'b01},
    {5'd19, 1'b0, 17'h1FFFF, 2'b11},
    {5'd20, 18'h00000, 2'b01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [16:0] ref_word;
  logic [17:0] fb_word;
  logic ref_upd, fb_upd;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [16:0] exp_ref = '0;
  logic [17:0] exp_fb = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_word(ref_word), .ref_upd(ref_upd), .fb_word(fb_word), .fb_upd(fb_upd)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_dat = b; tick(3);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0; tick(3);
  endtask

  task automatic send_frame(input logic [19:0] f, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit((i < 20) ? f[i] : 1'b1);
  endtask

  task automatic strobe(input int hold, output int rc, output int fc);
    @(negedge clk); ser_le = 1'b1;
    rc = 0; fc = 0;
    repeat (hold) begin
      @(negedge clk);
      rc += int'(ref_upd); fc += int'(fb_upd);
    end
    ser_le = 1'b0; tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc, fc;
    logic [19:0] f;
    logic [4:0]  n;
    tick(3); rst_n = 1'b1; tick(2);
    // R1 reset state
    chk("R1 ref_word", 32'(ref_word), 0);
    chk("R1 fb_word", 32'(fb_word), 0);
    chk("R1 flags", {30'd0, ref_upd, fb_upd}, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      n = VEC[v][24:20]; f = VEC[v][19:0];
      send_frame(f, int'(n));
      strobe(WIN, rc, fc);
      if (f[1:0] == 2'b11) exp_ref = f[18:2];
      if (f[1:0] == 2'b01) exp_fb = f[19:2];
      chk("R2/R3 ref_word", 32'(ref_word), 32'(exp_ref));
      chk("R2/R4/R7 fb_word", 32'(fb_word), 32'(exp_fb));
      chk("R5/R6 ref pulses", rc, (f[1:0] == 2'b11) ? 1 : 0);
      chk("R5/R6 fb pulses", fc, (f[1:0] == 2'b01) ? 1 : 0);
    end

    // R6: strobe held high long transfers once
    send_frame({1'b0, 17'h0F0F0, 2'b11}, 19);
    strobe(60, rc, fc);
    exp_ref = 17'h0F0F0;
    chk("R6 long strobe ref pulses", rc, 1);
    chk("R6 long strobe ref_word", 32'(ref_word), 32'(exp_ref));

    // R8: last serial edge coincides with strobe; stale window would read 01
    f = {1'b0, 17'h12344, 2'b11};
    for (int i = 18; i >= 1; i--) send_bit(f[i]);
    @(negedge clk); ser_dat = f[0]; tick(3);
    ser_clk = 1'b1; ser_le = 1'b1;
    rc = 0; fc = 0;
    repeat (WIN) begin
      @(negedge clk);
      rc += int'(ref_upd); fc += int'(fb_upd);
    end
    ser_clk = 1'b0; ser_le = 1'b0; tick(4);
    exp_ref = 17'h12344;
    chk("R8 ref_word", 32'(ref_word), 32'(exp_ref));
    chk("R8 ref pulses", rc, 1);
    chk("R8 fb pulses", fc, 0);
    chk("R8 fb_word kept", 32'(fb_word), 32'(exp_fb));

    // R1 again after mid-run reset
    @(negedge clk); rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
    chk("R1 ref_word after reset", 32'(ref_word), 0);
    chk("R1 fb_word after reset", 32'(fb_word), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule